// File: doc/BRIEF.md
# I2C Pad Recovery Pin Multiplexer

This block sits between an I2C engine and the two open-drain pads of its bus, clock and data. Normally the engine owns both pads: whenever it asks for a line to be pulled low, the pad's pull-down enable turns on. When the bus hangs, for example because a target is holding data low in the middle of a byte, software can take the pads away from the engine. It sets one mode bit, and from then on it drives and samples each line by hand through a small register port. The usual way out of such a hang is to toggle the clock until data is released.

In manual mode each pin has a direction bit and an output latch. The latch is changed only through a write-one-to-set register and a write-one-to-clear register, so software can move one line without a read-modify-write of the other. Both pads are open-drain. A latch value of 1, or an input direction, releases the pad. A latch value of 0 on an output pin pulls the pad low. The pad levels pass through a synchronizer before software can read them, and the engine always sees the raw pad levels.

Register map. All registers are read and written through the shared address port. In every register, bit 0 belongs to the clock pin and bit 1 belongs to the data pin.

- 0x48: mode register (bit 0 only).
- 0x4C: direction register.
- 0x50: input levels.
- 0x58: set register.
- 0x5C: clear register.

Top module: `i2c_pin_recovery_mux`

## Requirements
- R1: After reset the mode bit is 0 (engine control), both direction bits are 0 (input), and both output latches are 1.
- R2: Bit 0 of the mode register at 0x48 hands both pins to manual control when 1 and returns them to the engine when 0. The register reads back bit 0 only, and the other bits read as 0.
- R3: In engine mode, each pad pull-down enable equals the engine's drive-low request for that pin, in the same cycle.
- R4: The direction register at 0x4C makes the clock pin an output with bit 0 and the data pin an output with bit 1. It reads back as written.
- R5: Writing to the set register at 0x58 sets the output latch of every pin whose write bit is 1. Bits written as 0 leave their latch unchanged. Reading 0x58 returns both latches.
- R6: Writing to the clear register at 0x5C clears the output latch of every pin whose write bit is 1. Bits written as 0 leave their latch unchanged. Reading 0x5C returns both latches.
- R7: In manual mode, an output pin pulls its pad low exactly when its latch is 0. An input pin is always released, and the engine's requests have no effect on either pad.
- R8: Reading 0x50 returns the clock pad level in bit 0 and the data pad level in bit 1. Each level passes through a two-flop synchronizer, so a pad change first shows after the second rising clock edge that follows it.
- R9: Writes to 0x50 or to any unmapped offset change no register. Unmapped offsets read as 0.
- R10: The engine's clock and data inputs always carry the raw pad levels, in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Write strobe for the register port |
| reg_addr | input | 8 | Byte offset used for both reads and writes |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| eng_scl_low | input | 1 | Engine asks for the clock line to be pulled low |
| eng_sda_low | input | 1 | Engine asks for the data line to be pulled low |
| eng_scl_in | output | 1 | Clock pad level forwarded to the engine |
| eng_sda_in | output | 1 | Data pad level forwarded to the engine |
| pad_scl_in | input | 1 | Clock pad input level |
| pad_sda_in | input | 1 | Data pad input level |
| pad_scl_oe | output | 1 | Clock pad pull-down enable (1 pulls the line low) |
| pad_sda_oe | output | 1 | Data pad pull-down enable (1 pulls the line low) |

## Verification
A table of register writes walks the pins through every combination of direction and latch in manual mode. Each step is followed by a readback and a check of the pull-down enables, so a fault in the direction gating can be told apart from a fault in the latch update. The set and clear steps include writes where one bit is 1 and the other is 0, and a write of all zeros. These separate a correct per-bit update from a whole-register overwrite. Engine requests are toggled in both modes to show that the path switches, and pad levels are changed one edge at a time to pin down the two-cycle synchronizer delay.

// File: rtl/i2c_pin_mux_pkg.sv
package i2c_pin_mux_pkg;

    // Pin indices used in every register bit position
    localparam int PIN_SCL = 0;
    localparam int PIN_SDA = 1;
    localparam int NPINS   = 2;

    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 16;

    // Register offsets (software decodes these)
    localparam int OFS_MODE  = 'h48;
    localparam int OFS_DIR   = 'h4C;
    localparam int OFS_LEVEL = 'h50;
    localparam int OFS_SET   = 'h58;
    localparam int OFS_CLR   = 'h5C;

    typedef logic [NPINS-1:0] pin_vec_t;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_MODE,
        ACC_DIR,
        ACC_LEVEL,
        ACC_SET,
        ACC_CLR
    } acc_kind_t;

    typedef struct packed {
        logic     gpio_mode;
        pin_vec_t dir_out;
        pin_vec_t out_lvl;
    } mux_state_t;

    localparam mux_state_t MUX_RESET = '{gpio_mode: 1'b0, dir_out: '0, out_lvl: '1};

    function automatic acc_kind_t decode_offset(input logic [ADDR_W-1:0] a);
        case (a)
            ADDR_W'(OFS_MODE):  return ACC_MODE;
            ADDR_W'(OFS_DIR):   return ACC_DIR;
            ADDR_W'(OFS_LEVEL): return ACC_LEVEL;
            ADDR_W'(OFS_SET):   return ACC_SET;
            ADDR_W'(OFS_CLR):   return ACC_CLR;
            default:            return ACC_NONE;
        endcase
    endfunction

    // Open-drain: pull low only for a driven-low output
    function automatic logic gpio_pulls_low(input logic is_out, input logic lvl);
        return is_out & ~lvl;
    endfunction

endpackage

// File: rtl/i2c_pin_mux_regs.sv
module i2c_pin_mux_regs
    import i2c_pin_mux_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  pin_vec_t          level_sync,
    output logic [DATA_W-1:0] rdata,
    output mux_state_t        state
);

    mux_state_t state_q;
    mux_state_t state_d;
    acc_kind_t  kind;
    pin_vec_t   wbits;
    logic       unused_hi;

    assign kind      = decode_offset(addr);
    assign wbits     = wdata[NPINS-1:0];
    assign unused_hi = ^wdata[DATA_W-1:NPINS];

    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            case (kind)
                ACC_MODE: state_d.gpio_mode = wdata[0];
                ACC_DIR:  state_d.dir_out   = wbits;
                ACC_SET:  state_d.out_lvl   = state_q.out_lvl | wbits;
                ACC_CLR:  state_d.out_lvl   = state_q.out_lvl & ~wbits;
                default:  state_d = state_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= MUX_RESET;
        else     state_q <= state_d;
    end

    always_comb begin
        rdata = '0;
        case (kind)
            ACC_MODE:        rdata[0]         = state_q.gpio_mode;
            ACC_DIR:         rdata[NPINS-1:0] = state_q.dir_out;
            ACC_LEVEL:       rdata[NPINS-1:0] = level_sync;
            ACC_SET, ACC_CLR: rdata[NPINS-1:0] = state_q.out_lvl;
            default:         rdata = '0;
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/i2c_pin_mux_sync.sv
module i2c_pin_mux_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '1;
        else     chain_q <= {chain_q[STAGES-2:0], din};
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/i2c_pin_mux_pad.sv
module i2c_pin_mux_pad
    import i2c_pin_mux_pkg::*;
(
    input  logic gpio_mode,
    input  logic dir_out,
    input  logic out_lvl,
    input  logic eng_low,
    output logic pull_low
);

    always_comb begin
        if (gpio_mode) pull_low = gpio_pulls_low(dir_out, out_lvl);
        else           pull_low = eng_low;
    end

endmodule

// File: rtl/i2c_pin_recovery_mux.sv
module i2c_pin_recovery_mux
    import i2c_pin_mux_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              eng_scl_low,
    input  logic              eng_sda_low,
    output logic              eng_scl_in,
    output logic              eng_sda_in,
    input  logic              pad_scl_in,
    input  logic              pad_sda_in,
    output logic              pad_scl_oe,
    output logic              pad_sda_oe
);

    mux_state_t st;
    pin_vec_t   pad_in;
    pin_vec_t   eng_low;
    pin_vec_t   lvl_sync;
    pin_vec_t   pad_oe;
    logic       func_q;
    pin_vec_t   dir_q;
    pin_vec_t   out_q;

    assign pad_in[PIN_SCL]  = pad_scl_in;
    assign pad_in[PIN_SDA]  = pad_sda_in;
    assign eng_low[PIN_SCL] = eng_scl_low;
    assign eng_low[PIN_SDA] = eng_sda_low;

    i2c_pin_mux_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (reg_wr_en),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .level_sync (lvl_sync),
        .rdata      (reg_rdata),
        .state      (st)
    );

    assign func_q = st.gpio_mode;
    assign dir_q  = st.dir_out;
    assign out_q  = st.out_lvl;

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        i2c_pin_mux_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst  (rst),
            .din  (pad_in[p]),
            .dout (lvl_sync[p])
        );
        i2c_pin_mux_pad u_pad (
            .gpio_mode (func_q),
            .dir_out   (dir_q[p]),
            .out_lvl   (out_q[p]),
            .eng_low   (eng_low[p]),
            .pull_low  (pad_oe[p])
        );
    end

    assign pad_scl_oe = pad_oe[PIN_SCL];
    assign pad_sda_oe = pad_oe[PIN_SDA];
    assign eng_scl_in = pad_scl_in;
    assign eng_sda_in = pad_sda_in;

endmodule

// File: rtl/i2c_pin_recovery_mux_chk.sv
module i2c_pin_recovery_mux_chk
    import i2c_pin_mux_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              func,
    input pin_vec_t          dir,
    input pin_vec_t          out_lat,
    input pin_vec_t          eng_low,
    input pin_vec_t          pad_oe
);

    AST_RESET_VALUES: assert property (@(posedge clk)
        rst |=> (!func && dir == '0 && out_lat == '1)); // R1

    AST_ENGINE_PATH: assert property (@(posedge clk) disable iff (rst)
        !func |-> pad_oe == eng_low); // R3

    AST_INPUT_RELEASED: assert property (@(posedge clk) disable iff (rst)
        func |-> (pad_oe & ~dir) == '0); // R7

    AST_SET_RELEASES: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADDR_W'(OFS_SET) && wdata[PIN_SCL] && func && dir[PIN_SCL])
        |=> !pad_oe[PIN_SCL]); // R5

    AST_CLR_PULLS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADDR_W'(OFS_CLR) && wdata[PIN_SDA] && func && dir[PIN_SDA])
        |=> pad_oe[PIN_SDA]); // R6

    AST_LEVEL_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADDR_W'(OFS_LEVEL))
        |=> ($stable(func) && $stable(dir) && $stable(out_lat))); // R9

endmodule

bind i2c_pin_recovery_mux i2c_pin_recovery_mux_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (reg_wr_en),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .func    (func_q),
    .dir     (dir_q),
    .out_lat (out_q),
    .eng_low (eng_low),
    .pad_oe  (pad_oe)
);

// File: tb/tb_i2c_pin_recovery_mux.sv
module tb_i2c_pin_recovery_mux;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        eng_scl_low = 1'b0, eng_sda_low = 1'b0;
    logic        eng_scl_in, eng_sda_in;
    logic        pad_scl_in = 1'b1, pad_sda_in = 1'b1;
    logic        pad_scl_oe, pad_sda_oe;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    i2c_pin_recovery_mux dut (
        .clk(clk), .rst(rst),
        .reg_wr_en(wr_en), .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata),
        .eng_scl_low(eng_scl_low), .eng_sda_low(eng_sda_low),
        .eng_scl_in(eng_scl_in), .eng_sda_in(eng_sda_in),
        .pad_scl_in(pad_scl_in), .pad_sda_in(pad_sda_in),
        .pad_scl_oe(pad_scl_oe), .pad_sda_oe(pad_sda_oe)
    );

    // {write addr, write data, read addr, expected read, expected {sda_oe, scl_oe}}
    localparam logic [25:0] VEC [0:11] = '{
        {8'h4C, 4'h3, 8'h4C, 4'h3, 2'b00}, // R4 both outputs, engine mode
        {8'h48, 4'h1, 8'h48, 4'h1, 2'b00}, // R2 manual mode, latches high
        {8'h5C, 4'h1, 8'h58, 4'h2, 2'b01}, // R6 clear clock only
        {8'h5C, 4'h2, 8'h5C, 4'h0, 2'b11}, // R6 clear data only
        {8'h58, 4'h2, 8'h58, 4'h2, 2'b01}, // R5 set data only
        {8'h4C, 4'h2, 8'h4C, 4'h2, 2'b00}, // R7 clock input released
        {8'h5C, 4'h2, 8'h58, 4'h0, 2'b10}, // R6 data low
        {8'h58, 4'h0, 8'h58, 4'h0, 2'b10}, // R5 zero write no effect
        {8'h50, 4'h3, 8'h4C, 4'h2, 2'b10}, // R9 level write ignored
        {8'h60, 4'hF, 8'h60, 4'h0, 2'b10}, // R9 unmapped offset
        {8'h48, 4'h0, 8'h48, 4'h0, 2'b00}, // R2 back to engine
        {8'h48, 4'h2, 8'h48, 4'h0, 2'b00}  // R2 only bit 0 counts
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic reg_read(input logic [7:0] a);
        addr = a;
        #1;
    endtask

    function automatic logic [15:0] oe2();
        return {14'b0, pad_sda_oe, pad_scl_oe};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        reg_read(8'h48); check("R1 mode", rdata, 16'h0000);
        reg_read(8'h4C); check("R1 dir", rdata, 16'h0000);
        reg_read(8'h58); check("R1 latches", rdata, 16'h0003);
        check("R1 oe", oe2(), 16'h0000);

        for (int i = 0; i < 12; i++) begin
            logic [25:0] v;
            v = VEC[i];
            reg_write(v[25:18], {12'b0, v[17:14]});
            reg_read(v[13:6]);
            check($sformatf("R2 R4 R5 R6 R7 R9 vec%0d rdata", i), rdata, {12'b0, v[5:2]});
            check($sformatf("R3 R7 vec%0d oe", i), oe2(), {14'b0, v[1:0]});
        end

        // R3 engine path follows requests (mode 0 now)
        @(negedge clk); eng_scl_low = 1'b1; eng_sda_low = 1'b0; #1;
        check("R3 scl req", oe2(), 16'h0001);
        eng_scl_low = 1'b0; eng_sda_low = 1'b1; #1;
        check("R3 sda req", oe2(), 16'h0002);

        // R7 engine ignored in manual mode: dir=2, latches=00 -> only data pulls
        eng_scl_low = 1'b1; eng_sda_low = 1'b0;
        reg_write(8'h48, 16'h0001);
        #1; check("R7 engine ignored", oe2(), 16'h0002);
        eng_scl_low = 1'b0;
        reg_write(8'h48, 16'h0000);

        // R8 synchronizer delay
        reg_read(8'h50); check("R8 idle level", rdata, 16'h0003);
        @(negedge clk); pad_scl_in = 1'b0; pad_sda_in = 1'b1; #1;
        check("R10 eng scl", {14'b0, eng_sda_in, eng_scl_in}, 16'h0002);
        @(negedge clk); #1;
        check("R8 after one edge", rdata, 16'h0003);
        @(negedge clk); #1;
        check("R8 after two edges", rdata, 16'h0002);
        pad_scl_in = 1'b1; pad_sda_in = 1'b0; #1;
        check("R10 eng sda", {14'b0, eng_sda_in, eng_scl_in}, 16'h0001);
        repeat (2) @(negedge clk); #1;
        check("R8 data low", rdata, 16'h0001);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule